// File: doc/BRIEF.md
# Double-Rate Four-Port RAM Wrapper

This block gives a datapath on a base clock four independent word ports into one shared memory. Each port has its own address, write strobe, write data and read data, all on the base clock. The array behind them has only two physical ports. It is clocked on a second clock at exactly twice the base rate, with every second rising edge of that clock aligned to a base-clock rising edge. Each base cycle therefore holds two fast edges. Logical ports 0 and 1 use the two physical ports on the first fast edge, called phase 0, which falls mid-cycle. Logical ports 2 and 3 use them on the second fast edge, called phase 1, which coincides with the next base edge.

Requests are captured on a base-clock edge and held for both phases. A phase sequencer in the fast domain works out which phase each fast edge is. It does this by comparing a toggle flipped on every base edge with a fast-domain copy of that toggle. The sequencer has three states:
- SEQ_IDLE: no slow edge seen yet, or the slow clock has stopped.
- SEQ_AFTER0: phase 0 has just executed.
- SEQ_AFTER1: phase 1 has just executed.

Transitions:
- Any state moves to SEQ_AFTER0 on a first-half edge, where the toggles differ.
- SEQ_AFTER0 moves to SEQ_AFTER1 on the following edge.
- SEQ_AFTER1 moves to SEQ_IDLE, and SEQ_IDLE stays put, on an edge where the toggles match.

Phase 0 read results are parked in a holding register. On the phase 1 edge all four results are registered together.

Top module: `dpump_ram4`

## Requirements
- R1: While reset is held, and after its release until the first captured request completes, `port_rdata` reads all zeros.
- R2: A request driven before base edge n is captured at edge n. All four read results appear after edge n+1 and stay there for a full base cycle.
- R3: Logical ports 0 and 1 access the array on the mid-cycle fast edge (phase 0). Logical ports 2 and 3 access it on the fast edge aligned with the next base edge (phase 1).
- R4: In any base cycle, the four ports may be any mix of reads and writes. Each port's read data in lane k is `port_rdata[k*DATA_W +: DATA_W]`.
- R5: A phase 1 port reading an address written by a phase 0 port in the same base cycle returns the new data. A phase 0 port reading an address written by a phase 1 port in the same cycle returns the old data.
- R6: Two ports in the same phase, one reading and one writing the same address, give the reader the data held before that cycle.
- R7: When ports in different phases of one base cycle write the same address, the phase 1 write (port 2 or 3) is the one kept.
- R8: When both ports of one phase write the same address, the higher-numbered port wins: port 1 over port 0, and port 3 over port 2.
- R9: The array holds 2**ADDR_W independent words. It is never written on a fast edge that carries no phase.
- R10: `port_rdata` changes only on phase 1 edges. It is unchanged across the mid-cycle fast edge.
- R11: Write data on a port whose write strobe is 0 leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Base (datapath) clock |
| clk_fast | input | 1 | Array clock, twice base rate, rising edges aligned |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| port_addr | input | 4*ADDR_W | Word address per logical port, port k at bits k*ADDR_W |
| port_we | input | 4 | Write strobe per logical port |
| port_wdata | input | 4*DATA_W | Write data per logical port, port k at bits k*DATA_W |
| port_rdata | output | 4*DATA_W | Read data per logical port, port k at bits k*DATA_W |

## Verification
The assertions take for granted that the fast clock runs at exactly twice the base clock. They also assume every base rising edge lands on a fast rising edge. Without this, the toggle comparison cannot tell phase 0 from phase 1. Reset is assumed to be released away from both clocks' edges. The bench generates both clocks from one time base with the fast clock starting high, so the edges line up. It releases reset and changes every input between edges, several nanoseconds clear of any fast edge.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    localparam int NUM_LOGICAL = 4;
    localparam int NUM_PHYS    = 2;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_AFTER0 = 2'd1,
        SEQ_AFTER1 = 2'd2
    } seq_state_t;
endpackage

// File: rtl/dpr_req_capture.sv
module dpr_req_capture #(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int NL = 4
) (
    input  logic             clk_base,
    input  logic             rst_n,
    input  logic [NL*AW-1:0] in_addr,
    input  logic [NL-1:0]    in_we,
    input  logic [NL*DW-1:0] in_wdata,
    output logic [NL*AW-1:0] req_addr,
    output logic [NL-1:0]    req_we,
    output logic [NL*DW-1:0] req_wdata,
    output logic             slow_tog
);
    // Requests are held for both fast phases of the cycle.
    always_ff @(posedge clk_base or negedge rst_n) begin
        if (!rst_n) begin
            req_addr  <= '0;
            req_we    <= '0;
            req_wdata <= '0;
            slow_tog  <= 1'b0;
        end else begin
            req_addr  <= in_addr;
            req_we    <= in_we;
            req_wdata <= in_wdata;
            slow_tog  <= ~slow_tog;
        end
    end
endmodule

// File: rtl/dpr_phase_seq.sv
module dpr_phase_seq
    import dpr_pkg::*;
(
    input  logic clk_fast,
    input  logic rst_n,
    input  logic slow_tog,
    output logic exec0,
    output logic exec1
);
    seq_state_t state_q, state_nx;
    logic       tog_f;
    logic       first_half;

    // A toggle mismatch means a base edge happened on the previous fast edge,
    // so this edge is the mid-cycle one.
    assign first_half = slow_tog ^ tog_f;

    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            tog_f   <= 1'b0;
        end else begin
            state_q <= state_nx;
            tog_f   <= slow_tog;
        end
    end

    always_comb begin
        state_nx = state_q;
        exec0    = 1'b0;
        exec1    = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                exec0    = first_half;
                state_nx = first_half ? SEQ_AFTER0 : SEQ_IDLE;
            end
            SEQ_AFTER0: begin
                exec0    = first_half;
                exec1    = ~first_half;
                state_nx = first_half ? SEQ_AFTER0 : SEQ_AFTER1;
            end
            SEQ_AFTER1: begin
                exec0    = first_half;
                state_nx = first_half ? SEQ_AFTER0 : SEQ_IDLE;
            end
            default: begin
                state_nx = SEQ_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/dpr_port_mux.sv
module dpr_port_mux #(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int NP = 2
) (
    input  logic               exec0,
    input  logic               exec1,
    input  logic [2*NP*AW-1:0] req_addr,
    input  logic [2*NP-1:0]    req_we,
    input  logic [2*NP*DW-1:0] req_wdata,
    output logic [NP*AW-1:0]   ram_addr,
    output logic [NP-1:0]      ram_we,
    output logic [NP*DW-1:0]   ram_wdata
);
    // Physical port g serves logical g in phase 0 and logical g+NP in phase 1.
    for (genvar g = 0; g < NP; g++) begin : g_lane
        always_comb begin
            if (exec1) begin
                ram_addr[g*AW +: AW]  = req_addr[(g+NP)*AW +: AW];
                ram_wdata[g*DW +: DW] = req_wdata[(g+NP)*DW +: DW];
                ram_we[g]             = req_we[g+NP];
            end else begin
                ram_addr[g*AW +: AW]  = req_addr[g*AW +: AW];
                ram_wdata[g*DW +: DW] = req_wdata[g*DW +: DW];
                ram_we[g]             = exec0 & req_we[g];
            end
        end
    end
endmodule

// File: rtl/dpr_tdp_array.sv
module dpr_tdp_array #(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int NP = 2
) (
    input  logic             clk_fast,
    input  logic [NP*AW-1:0] ram_addr,
    input  logic [NP-1:0]    ram_we,
    input  logic [NP*DW-1:0] ram_wdata,
    output logic [NP*DW-1:0] ram_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Later loop index lands last, so port B beats port A on a shared address.
    always_ff @(posedge clk_fast) begin
        for (int p = 0; p < NP; p++) begin
            if (ram_we[p]) begin
                mem[ram_addr[p*AW +: AW]] <= ram_wdata[p*DW +: DW];
            end
        end
    end

    for (genvar g = 0; g < NP; g++) begin : g_rd
        assign ram_rdata[g*DW +: DW] = mem[ram_addr[g*AW +: AW]];
    end
endmodule

// File: rtl/dpr_read_collect.sv
module dpr_read_collect #(
    parameter int DW = 16,
    parameter int NP = 2
) (
    input  logic               clk_fast,
    input  logic               rst_n,
    input  logic               exec0,
    input  logic               exec1,
    input  logic [NP*DW-1:0]   ram_rdata,
    output logic [2*NP*DW-1:0] rdata_out
);
    logic [NP*DW-1:0] hold_q;

    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) begin
            hold_q    <= '0;
            rdata_out <= '0;
        end else begin
            if (exec0) begin
                hold_q <= ram_rdata;
            end
            if (exec1) begin
                rdata_out <= {ram_rdata, hold_q};
            end
        end
    end
endmodule

// File: rtl/dpump_ram4.sv
module dpump_ram4
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic                          clk_base,
    input  logic                          clk_fast,
    input  logic                          rst_n,
    input  logic [NUM_LOGICAL*ADDR_W-1:0] port_addr,
    input  logic [NUM_LOGICAL-1:0]        port_we,
    input  logic [NUM_LOGICAL*DATA_W-1:0] port_wdata,
    output logic [NUM_LOGICAL*DATA_W-1:0] port_rdata
);
    localparam int NL = NUM_LOGICAL;
    localparam int NP = NUM_PHYS;

    logic [NL*ADDR_W-1:0] req_addr;
    logic [NL-1:0]        req_we;
    logic [NL*DATA_W-1:0] req_wdata;
    logic                 slow_tog;
    logic                 exec0;
    logic                 exec1;
    logic [NP*ADDR_W-1:0] ram_addr;
    logic [NP-1:0]        ram_we;
    logic [NP*DATA_W-1:0] ram_wdata;
    logic [NP*DATA_W-1:0] ram_rdata;

    dpr_req_capture #(.AW(ADDR_W), .DW(DATA_W), .NL(NL)) u_cap (
        .clk_base (clk_base),
        .rst_n    (rst_n),
        .in_addr  (port_addr),
        .in_we    (port_we),
        .in_wdata (port_wdata),
        .req_addr (req_addr),
        .req_we   (req_we),
        .req_wdata(req_wdata),
        .slow_tog (slow_tog)
    );

    dpr_phase_seq u_seq (
        .clk_fast(clk_fast),
        .rst_n   (rst_n),
        .slow_tog(slow_tog),
        .exec0   (exec0),
        .exec1   (exec1)
    );

    dpr_port_mux #(.AW(ADDR_W), .DW(DATA_W), .NP(NP)) u_mux (
        .exec0    (exec0),
        .exec1    (exec1),
        .req_addr (req_addr),
        .req_we   (req_we),
        .req_wdata(req_wdata),
        .ram_addr (ram_addr),
        .ram_we   (ram_we),
        .ram_wdata(ram_wdata)
    );

    dpr_tdp_array #(.AW(ADDR_W), .DW(DATA_W), .NP(NP)) u_arr (
        .clk_fast (clk_fast),
        .ram_addr (ram_addr),
        .ram_we   (ram_we),
        .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata)
    );

    dpr_read_collect #(.DW(DATA_W), .NP(NP)) u_col (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .exec0    (exec0),
        .exec1    (exec1),
        .ram_rdata(ram_rdata),
        .rdata_out(port_rdata)
    );
endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input logic            clk_fast,
    input logic            rst_n,
    input logic            exec0,
    input logic            exec1,
    input logic [2*AW-1:0] ram_addr,
    input logic [1:0]      ram_we,
    input logic [4*AW-1:0] req_addr,
    input logic [4*DW-1:0] port_rdata
);
    AST_PHASE_PAIR: assert property (@(posedge clk_fast) disable iff (!rst_n)
        exec0 |=> exec1); // R3
    AST_PHASE1_AFTER0: assert property (@(posedge clk_fast) disable iff (!rst_n)
        exec1 |-> $past(exec0)); // R3
    AST_MAP_PH0: assert property (@(posedge clk_fast) disable iff (!rst_n)
        exec0 |-> (ram_addr == req_addr[2*AW-1:0])); // R3
    AST_MAP_PH1: assert property (@(posedge clk_fast) disable iff (!rst_n)
        exec1 |-> (ram_addr == req_addr[4*AW-1:2*AW])); // R3
    AST_MID_STABLE: assert property (@(posedge clk_fast) disable iff (!rst_n)
        exec0 |=> $stable(port_rdata)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (!exec0 && !exec1) |-> (ram_we == 2'b00)); // R9
endmodule

bind dpump_ram4 dpr_checker #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
    .clk_fast  (clk_fast),
    .rst_n     (rst_n),
    .exec0     (exec0),
    .exec1     (exec1),
    .ram_addr  (ram_addr),
    .ram_we    (ram_we),
    .req_addr  (req_addr),
    .port_rdata(port_rdata)
);

// File: tb/dpump_ram4_bench.sv
`timescale 1ns/1ps
module dpump_ram4_bench;
    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;

    logic clk_base = 1'b0;
    logic clk_fast = 1'b1;
    logic rst_n    = 1'b0;

    logic [AW-1:0] a_q  [4];
    logic          we_q [4];
    logic [DW-1:0] d_q  [4];

    logic [4*AW-1:0] port_addr;
    logic [3:0]      port_we;
    logic [4*DW-1:0] port_wdata;
    logic [4*DW-1:0] port_rdata;

    always #5   clk_base = ~clk_base;
    always #2.5 clk_fast = ~clk_fast;

    always_comb begin
        for (int k = 0; k < 4; k++) begin
            port_addr[k*AW +: AW]  = a_q[k];
            port_we[k]             = we_q[k];
            port_wdata[k*DW +: DW] = d_q[k];
        end
    end

    dpump_ram4 #(.ADDR_W(AW), .DATA_W(DW)) u_dpump_ram4 (
        .clk_base  (clk_base),
        .clk_fast  (clk_fast),
        .rst_n     (rst_n),
        .port_addr (port_addr),
        .port_we   (port_we),
        .port_wdata(port_wdata),
        .port_rdata(port_rdata)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [DW-1:0] model    [DEPTH];
    logic [DW-1:0] pend_exp [4];
    string         pend_tag;
    bit            pend_valid = 0;

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp, input int lane);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s lane %0d: actual=%h expected=%h", tag, lane, act, exp);
        end
    endtask

    task automatic set_port(input int p, input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d);
        a_q[p] = a; we_q[p] = w; d_q[p] = d;
    endtask

    task automatic read_all(input logic [AW-1:0] a);
        for (int p = 0; p < 4; p++) set_port(p, a, 1'b0, 16'hDEAD);
    endtask

    // Reference: phase 0 reads see memory before any write this cycle, then
    // ports 0,1 write (1 last), then ports 2,3 read, then ports 2,3 write (3 last).
    task automatic step(input string tag);
        logic [DW-1:0] e [4];
        logic [DW-1:0] snap [4];
        e[0] = model[a_q[0]];
        e[1] = model[a_q[1]];
        if (we_q[0]) model[a_q[0]] = d_q[0];
        if (we_q[1]) model[a_q[1]] = d_q[1];
        e[2] = model[a_q[2]];
        e[3] = model[a_q[3]];
        if (we_q[2]) model[a_q[2]] = d_q[2];
        if (we_q[3]) model[a_q[3]] = d_q[3];
        @(posedge clk_base);
        #2;
        if (pend_valid) begin
            for (int p = 0; p < 4; p++) begin
                if (!$isunknown(pend_exp[p]))
                    check(pend_tag, port_rdata[p*DW +: DW], pend_exp[p], p);
            end
        end
        for (int p = 0; p < 4; p++) snap[p] = port_rdata[p*DW +: DW];
        #4;
        if (pend_valid && !$isunknown(pend_exp[0]))
            check("R10 mid-edge hold", port_rdata[DW-1:0], snap[0], 0);
        pend_exp   = e;
        pend_tag   = tag;
        pend_valid = 1;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 'x;
        for (int p = 0; p < 4; p++) set_port(p, '0, 1'b0, '0);
        #23;
        check("R1 reset", port_rdata[DW-1:0], '0, 0);
        check("R1 reset", port_rdata[4*DW-1:3*DW], '0, 3);
        rst_n = 1'b1;
        #1;
        check("R1 after release", port_rdata[2*DW-1:DW], '0, 1);

        // R9 / R4: fill every word, four writes per cycle, top address included.
        for (int c = 0; c < DEPTH/4; c++) begin
            for (int p = 0; p < 4; p++)
                set_port(p, AW'(c*4+p), 1'b1, DW'((c*4+p)*37 + 5));
            step("R4 fill");
        end
        read_all(AW'(DEPTH-1));
        set_port(1, '0, 1'b0, '0);
        step("R9 extreme addresses");

        // R2 / R4: random mix of loads and stores.
        void'($urandom(7));
        for (int c = 0; c < 60; c++) begin
            for (int p = 0; p < 4; p++)
                set_port(p, AW'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), DW'($urandom));
            step("R2 random mix");
        end

        // R5: cross-phase forwarding and ordering.
        set_port(0, 6'd5, 1'b1, 16'hAAAA);
        set_port(1, 6'd5, 1'b0, 16'h0);
        set_port(2, 6'd5, 1'b0, 16'h0);
        set_port(3, 6'd7, 1'b1, 16'h7777);
        step("R5 phase order");
        set_port(0, 6'd7, 1'b0, 16'h0);
        set_port(1, 6'd9, 1'b1, 16'h9999);
        set_port(2, 6'd9, 1'b0, 16'h0);
        set_port(3, 6'd7, 1'b0, 16'h0);
        step("R5 phase order");

        // R6: same-phase read during write returns old data.
        set_port(0, 6'd20, 1'b1, 16'h2020);
        set_port(1, 6'd20, 1'b0, 16'h0);
        set_port(2, 6'd21, 1'b0, 16'h0);
        set_port(3, 6'd21, 1'b1, 16'h2121);
        step("R6 read-first");
        read_all(6'd21);
        step("R6 read-first");

        // R7: later phase write wins.
        set_port(0, 6'd12, 1'b0, 16'h0);
        set_port(1, 6'd12, 1'b1, 16'h1111);
        set_port(2, 6'd12, 1'b1, 16'h2222);
        set_port(3, 6'd13, 1'b1, 16'h3333);
        step("R7 later phase");
        set_port(0, 6'd13, 1'b1, 16'h4444);
        set_port(1, 6'd30, 1'b0, 16'h0);
        set_port(2, 6'd30, 1'b0, 16'h0);
        set_port(3, 6'd12, 1'b0, 16'h0);
        step("R7 later phase");
        read_all(6'd13);
        step("R7 later phase");

        // R8: same-phase write collision, higher port wins.
        set_port(0, 6'd14, 1'b1, 16'hA0A0);
        set_port(1, 6'd14, 1'b1, 16'hB1B1);
        set_port(2, 6'd15, 1'b1, 16'hC2C2);
        set_port(3, 6'd15, 1'b1, 16'hD3D3);
        step("R8 same phase");
        set_port(0, 6'd14, 1'b0, 16'h0);
        set_port(1, 6'd15, 1'b0, 16'h0);
        set_port(2, 6'd16, 1'b0, 16'h0);
        set_port(3, 6'd16, 1'b0, 16'h0);
        step("R8 same phase");
        for (int p = 0; p < 4; p++) set_port(p, 6'd16, 1'b1, DW'(16'h5000 + p));
        step("R8 all four");
        read_all(6'd16);
        step("R8 all four");

        // R11: strobe low with live data leaves memory alone.
        for (int p = 0; p < 4; p++) set_port(p, 6'd40, 1'b0, 16'hFFFF);
        step("R11 ignored data");
        read_all(6'd40);
        step("R11 ignored data");

        read_all(6'd0);
        step("R2 flush");
        step("R2 flush");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule